// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block collects a set of level-sensitive interrupt lines and folds them into one interrupt request for a processor. A pending register is loaded every clock with the current level of each line. It is not a sticky latch, so a source that drops its line also drops its pending bit, and software never has to clear it. Software chooses which sources may interrupt through a mask register. The request output is high while at least one source is both pending and enabled.

Software reaches the block through a simple single-cycle register port. Each access carries a valid strobe, a write flag, a byte address, byte enables and write data. A read returns its data one clock after it is accepted. The mask sits at byte offset 0x04 and can be read and written. The pending view at 0x0C is read-only. Offsets 0x00 and 0x14 accept writes, which change nothing and read back as zero. Every other offset reads as zero and drops writes. The number of sources is a parameter. Bit positions at or above that count read as zero in both the mask and the pending view.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous reset, the mask is zero, the pending bits are zero, `irq_req` is low, and a read of either register returns zero.
- R2: Each pending bit equals the level its input line had at the previous rising clock edge. A bit clears on the first edge after its line falls, without any software action. Offset 0x0C returns the pending bits.
- R3: `irq_req` is high exactly when the bitwise AND of mask and pending is nonzero. It follows a change on an input line one clock later.
- R4: Offset 0x04 holds the mask. A full-word write stores the written value, and a read returns it.
- R5: Offset 0x0C is read-only. A write to it leaves the pending bits and `irq_req` unchanged.
- R6: Writes to offsets 0x00 and 0x14 are accepted and change no state. Reads of these two offsets return zero.
- R7: Any byte offset other than 0x00, 0x04, 0x0C and 0x14 reads as zero, and writes to it are dropped. This includes misaligned offsets such as 0x05.
- R8: Only full-word accesses, with byte enables equal to 4'hF, take effect. A partial write leaves the mask unchanged. A partial read returns zero data but still produces a response.
- R9: Bit positions at or above the source count N_SRC read as zero in both the mask and the pending view. Mask bits written there are discarded.
- R10: Every accepted read produces exactly one `rd_valid` pulse, on the clock after the read. `rd_data` is zero whenever `rd_valid` is low.
- R11: A mask write changes `irq_req` from the clock edge that stores it. Clearing the mask lowers the request even while sources stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock; the interrupt lines are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N_SRC | Level-sensitive interrupt sources |
| req_valid | input | 1 | Register access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_be | input | 4 | Byte enables; only 4'hF is honoured |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe, one clock after the read |
| rd_data | output | 32 | Read response data, zero when `rd_valid` is low |
| irq_req | output | 1 | Combined interrupt request to the processor |

## Verification
If the pending register were corrupted, or failed to follow its line, the error would show within one clock, both on `irq_req` and in the next read of offset 0x0C. For this reason the bench reads the pending view back after each change to the input pattern. If the mask were corrupted, for example by a write to a dead, read-only, unmapped or partial-width offset, the damage stays hidden until a read of 0x04 or a change on a source line. The bench therefore reads the mask back after every write it expects to be dropped. If the read path lost track of its state, the response would come on the wrong cycle or with stray data. The scoreboard's in-order matching catches this on the next response.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [31:0] OFS_LVL  = 32'h00;
    localparam logic [31:0] OFS_MASK = 32'h04;
    localparam logic [31:0] OFS_PEND = 32'h0C;
    localparam logic [31:0] OFS_CTRL = 32'h14;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_LVL  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_PEND = 3'd3,
        SEL_CTRL = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              full;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_LVL:  s = SEL_LVL;
            OFS_MASK: s = SEL_MASK;
            OFS_PEND: s = SEL_PEND;
            OFS_CTRL: s = SEL_CTRL;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] src_valid_bits(input int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_pending_track.sv
module irq_pending_track
    import irq_ctrl_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  lines,
    output logic [DATA_W-1:0] pend_word
);

    logic [N_SRC-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= lines;
    end

    generate
        if (N_SRC < DATA_W) begin : g_pad
            assign pend_word = {{(DATA_W-N_SRC){1'b0}}, pend_q};
        end else begin : g_full
            assign pend_word = pend_q;
        end
    endgenerate

    assert_pend_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pend_q == $past(lines));

    assert_pend_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pend_q == '0);

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_ctrl_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_word
);

    localparam logic [DATA_W-1:0] KEEP = src_valid_bits(N_SRC);

    logic [DATA_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)     mask_q <= '0;
        else if (we) mask_q <= wdata & KEEP;
    end

    assign mask_word = mask_q;

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we)) |-> $stable(mask_q));

    generate
        if (N_SRC < DATA_W) begin : g_hi_chk
            assert_mask_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
                mask_q[DATA_W-1:N_SRC] == '0);
        end
    endgenerate

endmodule

// File: rtl/irq_reg_access.sv
module irq_reg_access
    import irq_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mask_word,
    input  logic [DATA_W-1:0] pend_word,
    output logic              mask_we,
    output logic [DATA_W-1:0] mask_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    bus_op_t           op;
    logic              rd_acc;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        op.valid = req_valid;
        op.write = req_write;
        op.full  = (req_be == {BE_W{1'b1}});
        op.sel   = decode_offset(32'(req_addr));
        op.wdata = req_wdata;
    end

    // Dead offsets (level-select, control), read-only view and unmapped
    // offsets fall through here with no write enable.
    assign mask_we    = op.valid && op.write && op.full && (op.sel == SEL_MASK);
    assign mask_wdata = op.wdata;
    assign rd_acc     = op.valid && !op.write;

    always_comb begin
        rd_mux = '0;
        if (op.full) begin
            case (op.sel)
                SEL_MASK: rd_mux = mask_word;
                SEL_PEND: rd_mux = pend_word;
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_acc;
            rd_data  <= rd_acc ? rd_mux : '0;
        end
    end

    assert_rd_response_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rd_valid == $past(rd_acc));

    assert_rd_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == '0);

    assert_partial_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_be != {BE_W{1'b1}}) |-> !mask_we);

endmodule

// File: rtl/irq_req_combine.sv
module irq_req_combine
    import irq_ctrl_pkg::*;
(
    input  logic [DATA_W-1:0] mask_word,
    input  logic [DATA_W-1:0] pend_word,
    output logic              irq_req
);

    logic [DATA_W-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_hit
            assign hit[gi] = mask_word[gi] & pend_word[gi];
        end
    endgenerate

    assign irq_req = |hit;

    always_comb begin
        assert_req_needs_both_R3: assert (!irq_req || (mask_word != '0 && pend_word != '0));
    end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_lines,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              irq_req
);

    logic [DATA_W-1:0] mask_word;
    logic [DATA_W-1:0] pend_word;
    logic              mask_we;
    logic [DATA_W-1:0] mask_wdata;

    irq_pending_track #(.N_SRC(N_SRC)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .lines     (irq_lines),
        .pend_word (pend_word)
    );

    irq_mask_reg #(.N_SRC(N_SRC)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .we        (mask_we),
        .wdata     (mask_wdata),
        .mask_word (mask_word)
    );

    irq_reg_access #(.ADDR_W(ADDR_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .mask_word  (mask_word),
        .pend_word  (pend_word),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    irq_req_combine u_comb (
        .mask_word (mask_word),
        .pend_word (pend_word),
        .irq_req   (irq_req)
    );

    assert_irq_low_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_req);

    assert_mask_clear_drops_req_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(mask_we) && $past(mask_wdata) == '0) |-> !irq_req);

endmodule

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;

    localparam int NS = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] irq_lines = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [7:0]    req_addr  = '0;
    logic [3:0]    req_be    = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          irq_req;

    int checks = 0;
    int fails  = 0;
    int n_req  = 0;
    int n_rsp  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    irq_level_ctrl #(.N_SRC(NS), .ADDR_W(8)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .irq_req   (irq_req)
    );

    // Monitor: pops the scoreboard on each response; checks idle data (R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rd_valid) begin
                n_rsp++;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R10 unexpected response actual=%h expected=none", rd_data);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rd_data !== e) begin
                        fails++;
                        $display("FAIL %s read actual=%h expected=%h", t, rd_data, e);
                    end
                end
            end else if (rd_data !== 32'h0) begin
                checks++;
                fails++;
                $display("FAIL R10 idle rd_data actual=%h expected=00000000", rd_data);
            end
        end
    end

    task automatic do_read(input logic [7:0] a, input logic [3:0] be,
                           input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        n_req++;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [3:0] be,
                            input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic set_lines(input logic [NS-1:0] v);
        @(negedge clk);
        irq_lines = v;
        @(negedge clk);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        checks++;
        if (irq_req !== exp) begin
            fails++;
            $display("FAIL %s irq_req actual=%b expected=%b", tag, irq_req, exp);
        end
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_irq(1'b0, "R1");
        do_read(8'h04, 4'hF, 32'h0, "R1 mask");
        do_read(8'h0C, 4'hF, 32'h0, "R1 pend");

        // R2/R3: pending follows levels; mask zero keeps irq low
        set_lines(24'hA5_0003);
        check_irq(1'b0, "R3 masked");
        do_read(8'h0C, 4'hF, 32'h00A5_0003, "R2 pend");

        // R11/R4: enabling bit0 raises the request
        do_write(8'h04, 4'hF, 32'h0000_0001);
        check_irq(1'b1, "R11 enable");
        do_read(8'h04, 4'hF, 32'h0000_0001, "R4 mask");

        // R2/R3: dropping line 0 clears pending and request next clock
        set_lines(24'hA5_0002);
        check_irq(1'b0, "R3 line drop");
        do_read(8'h0C, 4'hF, 32'h00A5_0002, "R2 cleared");

        // R9/R4: full write keeps only implemented bits
        do_write(8'h04, 4'hF, 32'hFFFF_FFFF);
        check_irq(1'b1, "R3 all enabled");
        do_read(8'h04, 4'hF, 32'h00FF_FFFF, "R9 mask upper");
        set_lines(24'hFF_FFFF);
        do_read(8'h0C, 4'hF, 32'h00FF_FFFF, "R9 pend upper");

        // R5: pending view is read-only
        do_write(8'h0C, 4'hF, 32'h0);
        check_irq(1'b1, "R5");
        do_read(8'h0C, 4'hF, 32'h00FF_FFFF, "R5 pend");

        // R6: dead offsets
        do_write(8'h04, 4'hF, 32'h0000_1230);
        do_write(8'h00, 4'hF, 32'hDEAD_BEEF);
        do_write(8'h14, 4'hF, 32'h0000_0000);
        do_read(8'h04, 4'hF, 32'h0000_1230, "R6 mask kept");
        do_read(8'h00, 4'hF, 32'h0, "R6 lvl read");
        do_read(8'h14, 4'hF, 32'h0, "R6 ctrl read");

        // R7: unmapped offsets
        do_write(8'h08, 4'hF, 32'h0);
        do_write(8'h05, 4'hF, 32'h0);
        do_write(8'h40, 4'hF, 32'h0);
        do_read(8'h04, 4'hF, 32'h0000_1230, "R7 mask kept");
        do_read(8'h08, 4'hF, 32'h0, "R7 read 08");
        do_read(8'h05, 4'hF, 32'h0, "R7 read 05");

        // R8: partial accesses
        do_write(8'h04, 4'h3, 32'h0);
        do_read(8'h04, 4'hF, 32'h0000_1230, "R8 partial write");
        do_read(8'h04, 4'h1, 32'h0, "R8 partial read");
        do_read(8'h0C, 4'hE, 32'h0, "R8 partial pend");

        // R11: clearing mask drops request with sources high
        do_write(8'h04, 4'hF, 32'h0);
        check_irq(1'b0, "R11 clear");
        set_lines(24'h80_0000);
        check_irq(1'b0, "R3 masked top");
        do_write(8'h04, 4'hF, 32'h0080_0000);
        check_irq(1'b1, "R3 top bit");

        // R10: back-to-back reads
        @(negedge clk);
        exp_q.push_back(32'h0080_0000); tag_q.push_back("R10 b2b 1"); n_req++;
        exp_q.push_back(32'h0080_0000); tag_q.push_back("R10 b2b 2"); n_req++;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h04; req_be = 4'hF;
        @(negedge clk);
        req_addr = 8'h0C;
        @(negedge clk);
        req_valid = 1'b0;

        drain();
        checks++;
        if (n_rsp != n_req || exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 responses actual=%0d expected=%0d", n_rsp, n_req);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule